// File: doc/BRIEF.md
# Serial Bus Response Receiver

This block takes over a bidirectional serial link once a command has gone out, and collects the reply from the remote target. It signals the pad logic to stop driving the data line, generates the serial clock itself, and samples the line once per clock period. The line is active low, so a low level counts as a logical 1. The block waits a bounded number of clock periods for a start bit. It then reads a reply header made of a target identifier and a response tag, an optional data field, and a 4-bit check code.

The data field is on the wire only when two things hold: the tag says the access was accepted, and the caller asked for data by giving a nonzero size code. Every other reply goes straight from the header to the check code. The check code covers the whole reply, starting with the start bit, and must leave a zero remainder. Each reply ends with exactly one outcome pulse: success, timeout or check-code error. The captured fields stay on the outputs until the next reply starts.

Top module: `rsp_receiver`

## Requirements
- R1: After reset, ser_clk_o is high, and rx_active_o, ok_o, timeout_o and crc_err_o are low. id_o, tag_o and data_o are zero.
- R2: A start_i seen while idle drives ser_clk_o low on the next edge. Each received bit then takes HALF_CYC cycles with the clock low and HALF_CYC cycles with it high. The bit is sampled at the last edge of the high half. ser_clk_o rests high whenever the block is idle.
- R3: The sampled value is the inverse of ser_dat_i. Before the start bit the block takes up to MAX_WAIT samples, and accepts a logical 1 at any of them, including sample number MAX_WAIT.
- R4: If MAX_WAIT samples in a row are all logical 0, the block pulses timeout_o, and id_o, tag_o and data_o read zero.
- R5: The four bits after the start bit form the header, most significant bit first. The first two are id_o[1:0] and the last two are tag_o[1:0].
- R6: Tag codes are 0 accepted, 1 busy, 2 general error and 3 target saw a bad check code. size_i (0 none, 1 eight bits, 2 sixteen bits, 3 thirty-two bits) is latched at start_i. Data bits follow the header only when the tag is 0 and size_i is nonzero. Otherwise the check code follows the header directly.
- R7: Data bits arrive most significant first and are right-justified in data_o, so the first byte received is the top byte of the value. Unused upper bits are zero. data_o is zero when there is no data field.
- R8: The check code uses polynomial x^4+x^2+x+1 with initial value 0, fed most significant bit first. It runs over the start bit, header, data and the 4 received check bits. A nonzero result pulses crc_err_o instead of ok_o.
- R9: Exactly one of ok_o, timeout_o and crc_err_o pulses high, for a single cycle. The pulse comes on the edge that follows the last sampled bit, and rx_active_o falls on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin receiving a reply (accepted when idle) |
| size_i | input | 2 | Expected data size code |
| ser_dat_i | input | 1 | Serial data line, active low |
| ser_clk_o | output | 1 | Generated serial clock |
| rx_active_o | output | 1 | High while receiving; the data line driver must be off |
| ok_o | output | 1 | Reply received with a good check code |
| timeout_o | output | 1 | No start bit within the wait limit |
| crc_err_o | output | 1 | Reply check code mismatch |
| id_o | output | 2 | Captured target identifier |
| tag_o | output | 2 | Captured response tag |
| data_o | output | 32 | Captured read data, right-justified |

## Verification
Count the edge that accepts start_i as edge 1. Bit k of the reply (zero-based, idle bits included) is sampled at edge 1 + 2·HALF_CYC·(k+1). The outcome pulse and the captured fields appear just after edge 1 + 2·HALF_CYC·n, where n is the number of bits sampled; n is MAX_WAIT for a timeout. The bench computes n from the reply it plays and counts rising edges from start_i to the first outcome. It compares the count against this formula, samples outputs one time unit after each edge, and checks one cycle later that the pulse has cleared.

// File: rtl/rsp_rx_pkg.sv
package rsp_rx_pkg;

  localparam int unsigned RSP_DATA_W = 32;
  localparam int unsigned RSP_HDR_W  = 4;
  localparam int unsigned RSP_CRC_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HDR,
    ST_DATA,
    ST_CRC
  } rx_state_e;

  typedef enum logic [1:0] {
    TAG_ACK  = 2'd0,
    TAG_BUSY = 2'd1,
    TAG_ERRG = 2'd2,
    TAG_ERRX = 2'd3
  } rsp_tag_e;

  typedef struct packed {
    logic ok;
    logic tmo;
    logic crc_err;
  } rx_outcome_t;

  function automatic int unsigned size_bits(input logic [1:0] code);
    case (code)
      2'd1:    return 8;
      2'd2:    return 16;
      2'd3:    return 32;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rsp_bit_timer.sv
module rsp_bit_timer #(
  parameter int unsigned HALF_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic active_i,
  input  logic stop_i,
  output logic ser_clk_o,
  output logic strobe_o
);

  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic ph_q, ph_d;
  logic at_end;

  generate
    if (HALF_CYC == 1) begin : g_nocnt
      assign at_end = 1'b1;
    end else begin : g_cnt
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (launch_i || !active_i || at_end) cnt_d = '0;
        else                                  cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign at_end = (cnt_q == CW'(HALF_CYC - 1));

      p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(HALF_CYC - 1));
    end
  endgenerate

  always_comb begin
    ph_d = ph_q;
    if (launch_i)       ph_d = 1'b0;
    else if (!active_i) ph_d = 1'b1;
    else if (at_end)    ph_d = !ph_q | stop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b1;
    else        ph_q <= ph_d;
  end

  assign ser_clk_o = ph_q;
  assign strobe_o  = active_i & ph_q & at_end;

  p_stop_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> strobe_o);

endmodule

// File: rtl/rsp_crc4.sv
module rsp_crc4 #(
  parameter int unsigned     W    = 4,
  parameter logic [W-1:0]    POLY = 4'h7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_nxt_o
);

  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  assign fb        = crc_q[W-1] ^ bit_i;
  assign crc_nxt_o = {crc_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);

  always_comb begin
    crc_d = crc_q;
    if (clr_i)     crc_d = '0;
    else if (en_i) crc_d = crc_nxt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  p_clr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_i && en_i));

endmodule

// File: rtl/rsp_rx_capture.sv
module rsp_rx_capture #(
  parameter int unsigned HDR_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              hdr_en_i,
  input  logic              dat_en_i,
  input  logic              bit_i,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [DATA_W-1:0] dat_o
);

  logic [HDR_W-1:0]  hdr_q, hdr_d;
  logic [DATA_W-1:0] dat_q, dat_d;

  always_comb begin
    hdr_d = hdr_q;
    dat_d = dat_q;
    if (clr_i) begin
      hdr_d = '0;
      dat_d = '0;
    end else begin
      if (hdr_en_i) hdr_d = {hdr_q[HDR_W-2:0], bit_i};
      if (dat_en_i) dat_d = {dat_q[DATA_W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      dat_q <= '0;
    end else begin
      hdr_q <= hdr_d;
      dat_q <= dat_d;
    end
  end

  assign hdr_o = hdr_q;
  assign dat_o = dat_q;

  p_one_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_en_i && dat_en_i));

endmodule

// File: rtl/rsp_rx_ctrl.sv
module rsp_rx_ctrl
  import rsp_rx_pkg::*;
#(
  parameter int unsigned MAX_WAIT = 1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [1:0]           size_i,
  input  logic                 strobe_i,
  input  logic                 bit_i,
  input  logic                 tag_msb_i,
  input  logic [RSP_CRC_W-1:0] crc_nxt_i,
  output logic                 launch_o,
  output logic                 active_o,
  output logic                 stop_o,
  output logic                 clr_o,
  output logic                 crc_en_o,
  output logic                 hdr_en_o,
  output logic                 dat_en_o,
  output rx_outcome_t          out_o
);

  localparam int unsigned WW  = $clog2(MAX_WAIT + 1);
  localparam int unsigned BCW = $clog2(RSP_DATA_W + 1);

  rx_state_e   state_q, state_d;
  logic [WW-1:0]  wait_q, wait_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic [1:0]     size_q, size_d;
  rx_outcome_t    out_q, out_d;
  logic [1:0]     tag_now;

  assign tag_now = {tag_msb_i, bit_i};

  always_comb begin
    state_d  = state_q;
    wait_d   = wait_q;
    bcnt_d   = bcnt_q;
    size_d   = size_q;
    out_d    = '0;
    launch_o = 1'b0;
    stop_o   = 1'b0;
    clr_o    = 1'b0;
    crc_en_o = 1'b0;
    hdr_en_o = 1'b0;
    dat_en_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          launch_o = 1'b1;
          clr_o    = 1'b1;
          size_d   = size_i;
          wait_d   = '0;
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (strobe_i) begin
          if (bit_i) begin
            crc_en_o = 1'b1;
            bcnt_d   = BCW'(RSP_HDR_W - 1);
            state_d  = ST_HDR;
          end else if (wait_q == WW'(MAX_WAIT - 1)) begin
            out_d.tmo = 1'b1;
            stop_o    = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            wait_d = wait_q + 1'b1;
          end
        end
      end
      ST_HDR: begin
        if (strobe_i) begin
          crc_en_o = 1'b1;
          hdr_en_o = 1'b1;
          if (bcnt_q == '0) begin
            if (tag_now == TAG_ACK && size_q != 2'd0) begin
              bcnt_d  = BCW'(size_bits(size_q) - 1);
              state_d = ST_DATA;
            end else begin
              bcnt_d  = BCW'(RSP_CRC_W - 1);
              state_d = ST_CRC;
            end
          end else begin
            bcnt_d = bcnt_q - 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (strobe_i) begin
          crc_en_o = 1'b1;
          dat_en_o = 1'b1;
          if (bcnt_q == '0) begin
            bcnt_d  = BCW'(RSP_CRC_W - 1);
            state_d = ST_CRC;
          end else begin
            bcnt_d = bcnt_q - 1'b1;
          end
        end
      end
      ST_CRC: begin
        if (strobe_i) begin
          crc_en_o = 1'b1;
          if (bcnt_q == '0) begin
            stop_o  = 1'b1;
            state_d = ST_IDLE;
            if (crc_nxt_i == '0) out_d.ok      = 1'b1;
            else                 out_d.crc_err = 1'b1;
          end else begin
            bcnt_d = bcnt_q - 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      bcnt_q  <= '0;
      size_q  <= '0;
      out_q   <= '0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      bcnt_q  <= bcnt_d;
      size_q  <= size_d;
      out_q   <= out_d;
    end
  end

  assign active_o = (state_q != ST_IDLE);
  assign out_o    = out_q;

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_q.ok, out_q.tmo, out_q.crc_err}));
  p_outcome_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q.ok || out_q.tmo || out_q.crc_err) |=> !(out_q.ok || out_q.tmo || out_q.crc_err));
  p_outcome_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q.ok || out_q.tmo || out_q.crc_err) |-> state_q == ST_IDLE);
  p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q < WW'(MAX_WAIT));

endmodule

// File: rtl/rsp_receiver.sv
module rsp_receiver
  import rsp_rx_pkg::*;
#(
  parameter int unsigned          HALF_CYC = 1,
  parameter int unsigned          MAX_WAIT = 1000,
  parameter logic [RSP_CRC_W-1:0] CRC_POLY = 4'h7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [1:0]            size_i,
  input  logic                  ser_dat_i,
  output logic                  ser_clk_o,
  output logic                  rx_active_o,
  output logic                  ok_o,
  output logic                  timeout_o,
  output logic                  crc_err_o,
  output logic [1:0]            id_o,
  output logic [1:0]            tag_o,
  output logic [RSP_DATA_W-1:0] data_o
);

  logic                  rx_bit;
  logic                  launch, active, stop, strobe;
  logic                  clr, crc_en, hdr_en, dat_en;
  logic [RSP_CRC_W-1:0]  crc_nxt;
  logic [RSP_HDR_W-1:0]  hdr;
  rx_outcome_t           outcome;

  assign rx_bit = ~ser_dat_i;

  rsp_bit_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .active_i (active),
    .stop_i   (stop),
    .ser_clk_o(ser_clk_o),
    .strobe_o (strobe)
  );

  rsp_rx_ctrl #(.MAX_WAIT(MAX_WAIT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .size_i   (size_i),
    .strobe_i (strobe),
    .bit_i    (rx_bit),
    .tag_msb_i(hdr[0]),
    .crc_nxt_i(crc_nxt),
    .launch_o (launch),
    .active_o (active),
    .stop_o   (stop),
    .clr_o    (clr),
    .crc_en_o (crc_en),
    .hdr_en_o (hdr_en),
    .dat_en_o (dat_en),
    .out_o    (outcome)
  );

  rsp_crc4 #(.W(RSP_CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .en_i     (crc_en),
    .bit_i    (rx_bit),
    .crc_nxt_o(crc_nxt)
  );

  rsp_rx_capture #(.HDR_W(RSP_HDR_W), .DATA_W(RSP_DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .hdr_en_i (hdr_en),
    .dat_en_i (dat_en),
    .bit_i    (rx_bit),
    .hdr_o    (hdr),
    .dat_o    (data_o)
  );

  assign rx_active_o = active;
  assign ok_o        = outcome.ok;
  assign timeout_o   = outcome.tmo;
  assign crc_err_o   = outcome.crc_err;
  assign id_o        = hdr[3:2];
  assign tag_o       = hdr[1:0];

  p_idle_clk_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active_o |-> ser_clk_o);
  p_launch_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active_o) |-> !ser_clk_o);
  p_tmo_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (id_o == 2'd0 && tag_o == 2'd0 && data_o == '0));
  p_nodata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o && tag_o != 2'd0) |-> data_o == '0);
  p_end_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_active_o) |-> (ok_o || timeout_o || crc_err_o));

endmodule

// File: tb/rsp_receiver_test.sv
module rsp_receiver_test;

  localparam int HALF = 1;
  localparam int WAITMAX = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic        ser_dat = 1'b1;
  logic        ser_clk;
  logic        rx_active, ok, tmo, crc_err;
  logic [1:0]  id, tag;
  logic [31:0] data;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  bit sb [0:2047];
  int slen = 0;
  int txn_no = 0;
  int sidx = 0;
  int seen_txn = -1;

  always #5 clk = ~clk;

  rsp_receiver #(.HALF_CYC(HALF), .MAX_WAIT(WAITMAX)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
    .ser_dat_i(ser_dat), .ser_clk_o(ser_clk), .rx_active_o(rx_active),
    .ok_o(ok), .timeout_o(tmo), .crc_err_o(crc_err),
    .id_o(id), .tag_o(tag), .data_o(data)
  );

  // remote target model: presents the next bit after each falling serial clock
  always @(negedge ser_clk) begin
    #1;
    if (seen_txn != txn_no) begin
      seen_txn = txn_no;
      sidx = 0;
    end
    if (sidx < slen) ser_dat = ~sb[sidx];
    else             ser_dat = 1'b1;
    sidx = sidx + 1;
  end

  task automatic check(input bit cond, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] crc_calc(input int lo, input int hi);
    logic [3:0] c = 4'h0;
    for (int i = lo; i < hi; i++) begin
      logic fb = c[3] ^ sb[i];
      c = {c[2:0], 1'b0} ^ (fb ? 4'h7 : 4'h0);
    end
    return c;
  endfunction

  // kind: 0 ok, 1 timeout, 2 crc error
  task automatic run_txn(input int delay, input logic [1:0] rid, input logic [1:0] rtag,
                         input logic [1:0] sz, input logic [31:0] dat,
                         input bit corrupt, input bit no_start);
    int n = 0;
    int hs;
    int nbits;
    int exp_n;
    int kind;
    int edges = 0;
    logic [3:0] c;
    logic [31:0] exp_data;
    bit got;
    for (int i = 0; i < delay; i++) begin sb[n] = 1'b0; n++; end
    nbits = (rtag == 2'd0 && sz != 2'd0) ? (8 << (sz - 1)) : 0;
    if (!no_start) begin
      hs = n;
      sb[n] = 1'b1; n++;
      sb[n] = rid[1]; n++;  sb[n] = rid[0]; n++;
      sb[n] = rtag[1]; n++; sb[n] = rtag[0]; n++;
      for (int j = nbits - 1; j >= 0; j--) begin sb[n] = dat[j]; n++; end
      c = crc_calc(hs, n);
      for (int j = 3; j >= 0; j--) begin sb[n] = c[j]; n++; end
      if (corrupt) sb[n-1] = ~sb[n-1];
    end
    slen = n;
    txn_no = txn_no + 1;
    kind = no_start ? 1 : (corrupt ? 2 : 0);
    exp_n = no_start ? WAITMAX : n;
    if (nbits == 0)       exp_data = 32'h0;
    else if (nbits == 32) exp_data = dat;
    else                  exp_data = dat & ((32'h1 << nbits) - 1);

    @(negedge clk);
    start_i = 1'b1;
    size_i  = sz;
    got = 0;
    while (!got && edges < 6000) begin
      @(posedge clk);
      edges++;
      #1;
      start_i = 1'b0;
      if (ok || tmo || crc_err) got = 1;
    end
    check(got, "R9 outcome seen", {63'd0, got}, 64'd1);
    check(edges == 1 + 2 * HALF * exp_n, "R2 R9 latency", edges, 1 + 2 * HALF * exp_n);
    check({ok, tmo, crc_err} == {kind == 0, kind == 1, kind == 2},
          kind == 1 ? "R4 timeout" : (kind == 2 ? "R8 crc error" : "R3 R8 ok"),
          {ok, tmo, crc_err}, {kind == 0, kind == 1, kind == 2});
    check(!rx_active, "R9 inactive at outcome", rx_active, 0);
    if (kind == 1) begin
      check(id == 0 && tag == 0 && data == 0, "R4 fields cleared",
            {id, tag, data}, 0);
    end else begin
      check(id == rid, "R5 id", id, rid);
      check(tag == rtag, "R5 R6 tag", tag, rtag);
      if (kind == 0) check(data == exp_data, "R6 R7 data", data, exp_data);
    end
    @(posedge clk); #1;
    check(!(ok || tmo || crc_err), "R9 single pulse", {ok, tmo, crc_err}, 0);
    check(ser_clk && !rx_active, "R2 idle clock high", {ser_clk, rx_active}, 2'b10);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check(ser_clk && !rx_active && !ok && !tmo && !crc_err, "R1 reset controls",
          {ser_clk, rx_active, ok, tmo, crc_err}, 5'b10000);
    check(id == 0 && tag == 0 && data == 0, "R1 reset fields", {id, tag, data}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(ser_clk && !rx_active, "R1 after release", {ser_clk, rx_active}, 2'b10);

    // directed corners
    run_txn(0,   2'd2, 2'd0, 2'd3, 32'hA1B2C3D4, 0, 0); // R7 32-bit, first byte on top
    run_txn(3,   2'd1, 2'd0, 2'd1, 32'h0000005A, 0, 0); // R7 8-bit
    run_txn(2,   2'd3, 2'd0, 2'd2, 32'hFFFF8001, 0, 0); // R7 16-bit, upper zero
    run_txn(1,   2'd0, 2'd0, 2'd0, 32'hDEADBEEF, 0, 0); // R6 no data requested
    run_txn(4,   2'd1, 2'd1, 2'd3, 32'h12345678, 0, 0); // R6 busy: no data field
    run_txn(0,   2'd2, 2'd2, 2'd2, 32'h0, 0, 0);        // R6 general error
    run_txn(5,   2'd3, 2'd3, 2'd1, 32'h0, 0, 0);        // R6 target check error
    run_txn(1,   2'd1, 2'd0, 2'd3, 32'h0F0F0F0F, 1, 0); // R8 corrupted check code
    run_txn(999, 2'd2, 2'd0, 2'd1, 32'h000000C3, 0, 0); // R3 start at last allowed sample
    run_txn(0,   2'd0, 2'd0, 2'd0, 32'h0, 0, 1);        // R4 no start bit at all

    // random mix
    for (int t = 0; t < 40; t++) begin
      run_txn($urandom_range(0, 20), 2'($urandom), 2'($urandom_range(0, 3) == 0 ?
              $urandom : 0), 2'($urandom), $urandom, ($urandom_range(0, 7) == 0), 0);
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      failures++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule